// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a single-rank SDR SDRAM. It takes the memory from power-on to normal operation. After a start pulse it waits through a power-up pause with the clock enabled and only NOP on the command pins. It then issues one precharge to every bank and eight auto-refresh commands. Last comes a mode register load that selects single-beat sequential bursts and the configured CAS latency. Once the mode register delay has passed, it raises a permanent ready flag.

From then on an internal interval timer produces refresh requests. The controller's arbiter acknowledges each request when it has issued the refresh. The timer reloads the moment a request is raised, so how long the arbiter takes to acknowledge never shifts the refresh period. All command pins are registered outputs.

The spacing between commands comes from run-time inputs, given in clock cycles: row precharge time, refresh cycle time and mode register delay. The pause length is a cycle count computed at elaboration from the clock frequency and pause duration parameters.

Top module: `sdram_boot_seq`

## Requirements
- R1: While reset is high, and after it until a start pulse, cke is 0, cs_n is 1, ras_n/cas_n/we_n are 1, init_done is 0 and ref_req is 0. Reset is synchronous and active high.
- R2: A start pulse is acted on only in the idle state. A start pulse during the pause or in normal mode changes neither the command sequence nor its timing nor the outputs.
- R3: The power-up pause begins on the cycle after the clock edge that captures start. It lasts exactly PAUSE_CYC = CLK_MHZ*PAUSE_US cycles, with cke 1 and NOP (cs_n 0, ras_n 1, cas_n 1, we_n 1). The first command follows at once.
- R4: The first command is precharge-all: cs_n 0, ras_n 0, cas_n 1, we_n 0, with addr[10] = 1.
- R5: After the precharge come exactly eight auto-refresh commands (ras_n 0, cas_n 0, we_n 1), then exactly one mode register load (ras_n 0, cas_n 0, we_n 0). No other command is issued during start-up.
- R6: The precharge is followed by the next command after max(t_rp,2) cycles. Each auto-refresh is followed by the next command after max(t_rc,2) cycles. Every command cycle is followed by at least one NOP cycle.
- R7: During the mode register load, addr[6:4] carries cas_lat, addr[3] (burst type) is 0, addr[2:0] (burst length code) is 000, all other address bits are 0, and ba is 0.
- R8: init_done rises max(t_mrd,2) cycles after the mode register load cycle. It then stays 1 until reset.
- R9: While init_done is 1, cke is 1 and the command pins carry NOP.
- R10: ref_req first rises ref_interval cycles after init_done rises. A new request is raised every ref_interval cycles after that, however late the acknowledges come.
- R11: ref_req stays 1 until a cycle with ref_ack 1, and is 0 on the cycle after that. It stays 1 instead when a new interval ends in the same cycle as the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins the power-up sequence when idle |
| cas_lat | input | 3 | CAS latency written into the mode word |
| t_rp | input | TW | Precharge-to-command spacing, cycles |
| t_rc | input | TW | Refresh-to-command spacing, cycles |
| t_mrd | input | TW | Mode-load-to-ready spacing, cycles |
| ref_interval | input | RI_W | Cycles between refresh requests |
| ref_ack | input | 1 | Clears a pending refresh request |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | SDRAM chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Start-up finished, normal mode |
| ref_req | output | 1 | Pending refresh request |

## Verification
The assertions assume that t_rp, t_rc, t_mrd, cas_lat and ref_interval stay stable from the start pulse onward. They also assume ref_interval is at least 1 and that ref_ack is only raised while a request is pending. The bench changes the timing inputs only while reset is high. It raises ref_ack for a single cycle, and only once it has seen ref_req at 1. In the acknowledge-collision case it aims that single cycle at the cycle in which the next interval ends.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PAUSE,
    ST_PRE,
    ST_WAIT_RP,
    ST_REF,
    ST_WAIT_RC,
    ST_MRS,
    ST_WAIT_MRD,
    ST_RUN
  } boot_state_t;

  typedef enum logic [2:0] {
    CMD_DESEL,
    CMD_NOP,
    CMD_PRECHG,
    CMD_AREF,
    CMD_LOADMODE
  } sdram_cmd_t;

  // {cs_n, ras_n, cas_n, we_n}
  function automatic logic [3:0] cmd_pins(input sdram_cmd_t c);
    case (c)
      CMD_NOP:      return 4'b0111;
      CMD_PRECHG:   return 4'b0010;
      CMD_AREF:     return 4'b0001;
      CMD_LOADMODE: return 4'b0000;
      default:      return 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (load)      cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - CW'(1);
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int RI_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [RI_W-1:0] interval,
  output logic            tick
);
  logic [RI_W-1:0] cnt;
  logic [RI_W-1:0] reload;

  assign reload = interval - RI_W'(1);
  assign tick   = en && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (!en)     cnt <= reload;
    else if (tick)    cnt <= reload;
    else              cnt <= cnt - RI_W'(1);
  end
endmodule

// File: rtl/sdram_pin_drive.sv
module sdram_pin_drive
  import sdram_boot_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  sdram_cmd_t        cmd_d,
  input  logic              cke_d,
  input  logic [ADDR_W-1:0] addr_d,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cke                        <= 1'b0;
      {cs_n, ras_n, cas_n, we_n} <= 4'b1111;
      ba                         <= '0;
      addr                       <= '0;
    end else begin
      cke                        <= cke_d;
      {cs_n, ras_n, cas_n, we_n} <= cmd_pins(cmd_d);
      ba                         <= '0;
      addr                       <= addr_d;
    end
  end
endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
  import sdram_boot_pkg::*;
#(
  parameter int CLK_MHZ  = 100,
  parameter int PAUSE_US = 200,
  parameter int ADDR_W   = 13,
  parameter int BA_W     = 2,
  parameter int TW       = 4,
  parameter int RI_W     = 16,
  parameter int REF_NUM  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        cas_lat,
  input  logic [TW-1:0]     t_rp,
  input  logic [TW-1:0]     t_rc,
  input  logic [TW-1:0]     t_mrd,
  input  logic [RI_W-1:0]   ref_interval,
  input  logic              ref_ack,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done,
  output logic              ref_req
);
  localparam int PAUSE_CYC = CLK_MHZ * PAUSE_US;
  localparam int PW        = $clog2(PAUSE_CYC + 1);
  localparam int CW        = (PW > TW) ? PW : TW;
  localparam int RCW       = $clog2(REF_NUM + 1);

  boot_state_t     state, state_d;
  logic [RCW-1:0]  ref_cnt;
  logic            gap_ld, gap_zero, ref_tick;
  logic [CW-1:0]   gap_val;
  logic [CW-1:0]   rp_x, rc_x, mrd_x, gap_rp, gap_rc, gap_mrd;
  sdram_cmd_t      cmd_d;
  logic [ADDR_W-1:0] addr_d;

  // a wait state of n+1 cycles gives a command spacing of n+2 (never below 2)
  assign rp_x    = CW'(t_rp);
  assign rc_x    = CW'(t_rc);
  assign mrd_x   = CW'(t_mrd);
  assign gap_rp  = (rp_x  < CW'(2)) ? '0 : rp_x  - CW'(2);
  assign gap_rc  = (rc_x  < CW'(2)) ? '0 : rc_x  - CW'(2);
  assign gap_mrd = (mrd_x < CW'(2)) ? '0 : mrd_x - CW'(2);

  always_comb begin
    state_d = state;
    gap_ld  = 1'b0;
    gap_val = '0;
    case (state)
      ST_IDLE: if (start) begin
        state_d = ST_PAUSE;
        gap_ld  = 1'b1;
        gap_val = CW'(PAUSE_CYC - 1);
      end
      ST_PAUSE:    if (gap_zero) state_d = ST_PRE;
      ST_PRE: begin
        state_d = ST_WAIT_RP;
        gap_ld  = 1'b1;
        gap_val = gap_rp;
      end
      ST_WAIT_RP:  if (gap_zero) state_d = ST_REF;
      ST_REF: begin
        state_d = ST_WAIT_RC;
        gap_ld  = 1'b1;
        gap_val = gap_rc;
      end
      ST_WAIT_RC:  if (gap_zero)
        state_d = (ref_cnt == RCW'(REF_NUM)) ? ST_MRS : ST_REF;
      ST_MRS: begin
        state_d = ST_WAIT_MRD;
        gap_ld  = 1'b1;
        gap_val = gap_mrd;
      end
      ST_WAIT_MRD: if (gap_zero) state_d = ST_RUN;
      ST_RUN:      state_d = ST_RUN;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ref_cnt   <= '0;
      init_done <= 1'b0;
    end else begin
      state <= state_d;
      if (state == ST_IDLE)     ref_cnt <= '0;
      else if (state == ST_REF) ref_cnt <= ref_cnt + RCW'(1);
      if (state_d == ST_RUN)    init_done <= 1'b1;
    end
  end

  // next-state command decode, registered in the pin driver
  always_comb begin
    addr_d = '0;
    case (state_d)
      ST_IDLE:  cmd_d = CMD_DESEL;
      ST_PRE: begin
        cmd_d      = CMD_PRECHG;
        addr_d[10] = 1'b1;
      end
      ST_REF:   cmd_d = CMD_AREF;
      ST_MRS: begin
        cmd_d       = CMD_LOADMODE;
        addr_d[6:4] = cas_lat;
      end
      default:  cmd_d = CMD_NOP;
    endcase
  end

  sdram_gap_timer #(.CW(CW)) u_gap (
    .clk(clk), .rst(rst), .load(gap_ld), .load_val(gap_val), .zero(gap_zero)
  );

  sdram_refresh_timer #(.RI_W(RI_W)) u_rtmr (
    .clk(clk), .rst(rst), .en(state == ST_RUN),
    .interval(ref_interval), .tick(ref_tick)
  );

  sdram_pin_drive #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_pins (
    .clk(clk), .rst(rst), .cmd_d(cmd_d), .cke_d(state_d != ST_IDLE),
    .addr_d(addr_d), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr)
  );

  always_ff @(posedge clk) begin
    if (rst)           ref_req <= 1'b0;
    else if (ref_tick) ref_req <= 1'b1;
    else if (ref_ack)  ref_req <= 1'b0;
  end

  a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);
  a_r10_req_after_done: assert property (@(posedge clk) disable iff (rst)
    ref_req |-> init_done);
  a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
    (ref_req && !ref_ack) |=> ref_req);
  a_r6_nop_follows: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !ras_n) |=> ras_n);
  a_r4_pre_a10: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !ras_n && cas_n && !we_n) |-> addr[10]);
  a_r7_mode_low_bits: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !ras_n && !cas_n && !we_n) |-> (addr[3:0] == 4'd0 && ba == '0));
  a_r9_run_quiet: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (cke && ras_n && cas_n && we_n));
endmodule

// File: tb/sdram_boot_seq_test.sv
module sdram_boot_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_MHZ    = 2;
  localparam int PAUSE_US   = 200;
  localparam int PAUSE_CYC  = CLK_MHZ * PAUSE_US;

  logic clk = 0, rst = 1, start = 0, ref_ack = 0;
  logic [2:0]  cas_lat = 3'd2;
  logic [3:0]  t_rp = 4'd2, t_rc = 4'd2, t_mrd = 4'd3;
  logic [15:0] ref_interval = 16'd10;
  logic cke, cs_n, ras_n, cas_n, we_n, init_done, ref_req;
  logic [1:0]  ba;
  logic [12:0] addr;

  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_boot_seq #(.CLK_MHZ(CLK_MHZ), .PAUSE_US(PAUSE_US)) uut (
    .clk(clk), .rst(rst), .start(start), .cas_lat(cas_lat), .t_rp(t_rp),
    .t_rc(t_rc), .t_mrd(t_mrd), .ref_interval(ref_interval), .ref_ack(ref_ack),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .init_done(init_done), .ref_req(ref_req)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int spacing(input int t);
    return (t < 2) ? 2 : t;
  endfunction

  function automatic bit is_nop();
    return !cs_n && ras_n && cas_n && we_n;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1; start = 0; ref_ack = 0;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  // runs start-up and checks it; returns at the negedge where init_done is first seen
  task automatic do_init(input int trp, input int trc, input int tmrd,
                         input int cl, input bit poke);
    int ck[16]; int kd[16]; int ncmd = 0; int pause_cnt = 0; int done_k = -1;
    logic [12:0] pre_addr = '0, mrs_addr = '0; logic [1:0] mrs_ba = '0;
    rst = 1;
    t_rp = 4'(trp); t_rc = 4'(trc); t_mrd = 4'(tmrd); cas_lat = 3'(cl);
    do_reset();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    for (int k = 0; k < 4000; k++) begin
      if (init_done) begin done_k = k; break; end
      if (!cs_n && !ras_n) begin
        if (ncmd < 16) begin
          ck[ncmd] = k;
          kd[ncmd] = (cas_n && !we_n) ? 1 : (!cas_n && we_n) ? 2 : (!cas_n && !we_n) ? 3 : 0;
          if (kd[ncmd] == 1) pre_addr = addr;
          if (kd[ncmd] == 3) begin mrs_addr = addr; mrs_ba = ba; end
        end
        ncmd++;
      end else if (ncmd == 0 && cke && is_nop()) pause_cnt++;
      start = (poke && k == 5);
      @(negedge clk);
    end
    start = 0;
    chk(pause_cnt == PAUSE_CYC, "R3 pause length", pause_cnt, PAUSE_CYC);
    chk(ncmd > 0 && ck[0] == PAUSE_CYC, "R3/R2 first command cycle", ck[0], PAUSE_CYC);
    chk(ncmd == 10, "R5 command count", ncmd, 10);
    if (ncmd == 10) begin
      chk(kd[0] == 1 && pre_addr[10], "R4 precharge all", kd[0], 1);
      for (int i = 1; i <= 8; i++) chk(kd[i] == 2, "R5 auto refresh", kd[i], 2);
      chk(kd[9] == 3, "R5 mode load last", kd[9], 3);
      chk(ck[1] - ck[0] == spacing(trp), "R6 precharge spacing", ck[1] - ck[0], spacing(trp));
      for (int i = 1; i <= 8; i++)
        chk(ck[i+1] - ck[i] == spacing(trc), "R6 refresh spacing", ck[i+1] - ck[i], spacing(trc));
      chk(mrs_addr == 13'(cl << 4) && mrs_ba == 2'd0, "R7 mode word", int'(mrs_addr), cl << 4);
      chk(done_k - ck[9] == spacing(tmrd), "R8 ready delay", done_k - ck[9], spacing(tmrd));
    end
    chk(cke && is_nop() && !ref_req, "R9 quiet on ready", int'(cke), 1);
  endtask

  task automatic test_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    chk(!cke && cs_n && ras_n && cas_n && we_n, "R1 pins in reset", int'(cke), 0);
    chk(!init_done && !ref_req, "R1 flags in reset", int'(init_done), 0);
    rst = 0;
    repeat (5) @(negedge clk);
    chk(!cke && cs_n && !init_done, "R1 idle without start", int'(cs_n), 1);
  endtask

  task automatic test_refresh_prompt();
    int rises[4]; int nr = 0; logic prev = 0;
    ref_interval = 16'd10;
    do_init(2, 2, 2, 2, 0);
    for (int j = 1; j <= 35; j++) begin
      @(negedge clk);
      ref_ack = 0;
      if (ref_req && !prev) begin
        if (nr < 4) rises[nr] = j;
        nr++;
        ref_ack = 1;
      end
      if (prev && !ref_req) chk(1, "R11 cleared by ack", 0, 0);
      if (prev && ref_req) chk(0, "R11 clear after ack", 1, 0);
      chk(init_done && cke && is_nop(), "R9 quiet in run", int'(is_nop()), 1);
      prev = ref_req;
    end
    ref_ack = 0;
    chk(nr == 3, "R10 request count", nr, 3);
    for (int i = 0; i < 3 && i < nr; i++)
      chk(rises[i] == 10 * (i + 1), "R10 request period", rises[i], 10 * (i + 1));
    // start in normal mode is ignored
    start = 1; @(negedge clk); start = 0;
    for (int j = 0; j < 12; j++) begin
      chk(init_done && cke && is_nop(), "R2 start ignored in run", int'(init_done), 1);
      @(negedge clk);
    end
  endtask

  task automatic test_refresh_hold();
    ref_interval = 16'd6;
    do_init(3, 4, 1, 3, 0);
    for (int j = 1; j <= 17; j++) begin
      @(negedge clk);
      if (j < 6) chk(!ref_req, "R10 no early request", int'(ref_req), 0);
      else chk(ref_req, "R11 held without ack", int'(ref_req), 1);
    end
    ref_ack = 1;                // acknowledge during the cycle a new interval ends
    @(negedge clk);
    chk(ref_req, "R11 tick beats ack", int'(ref_req), 1);
    @(negedge clk);             // ack applied to a cycle with no tick
    ref_ack = 0;
    chk(!ref_req, "R11 ack clears", int'(ref_req), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    test_reset();
    do_init(3, 7, 3, 2, 1);   // start poked during the pause (R2)
    do_init(1, 1, 1, 3, 0);   // minimum spacing
    do_init(5, 9, 4, 7, 0);
    test_refresh_prompt();
    test_refresh_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule